// File: doc/BRIEF.md
# Modulo and Bit-Reversed Data Address Generator

This block computes the data-memory address for one operand port of a processor datapath. It has one cycle of latency. Each cycle it takes the current pointer register value, an addressing mode, an offset, the bounds of a circular buffer, a bit-reverse modifier and a byte/word select. From these it returns the effective address to present to memory and the pointer value to write back to the register file. It also flags a word access that would land on an odd address.

The pointer can stay unchanged, be stepped up or down before or after use, or be combined with a register offset or with a literal offset. A literal offset is scaled by the access size. When circular addressing is enabled, a step that leaves the inclusive window from buffer start to buffer end re-enters at the other end, carrying the overshoot with it. When bit-reversed addressing is enabled, a post-increment adds the modifier with its carry running from high to low bit across the element index field, which walks an FFT operand array in reversed order.

A build parameter picks the variant. The full variant has every mode. The reduced variant leaves out the bit-reversal hardware and ignores the enable for it. The two generators that feed a dual-operand multiply-accumulate are two instances of this block, one with each variant. Each issues one address every cycle.

Top module: `agen_port`

## Requirements
- R1: While reset is held, out_valid, ea, ptr_out and align_err are all 0.
- R2: A request with req_valid=1 is presented on the outputs at the next rising edge with out_valid=1. A cycle with req_valid=0 gives out_valid=0 at the next edge, and ea, ptr_out and align_err keep their values.
- R3: Modes 0 (indirect) and 7 (reserved) give ea = ptr_in and ptr_out = ptr_in.
- R4: Modes 1 (post-increment) and 2 (post-decrement) give ea = ptr_in and ptr_out = ptr_in plus or minus the step. The step is 1 when byte_sel=1 and 2 when byte_sel=0.
- R5: Modes 3 (pre-increment) and 4 (pre-decrement) give ptr_out = ptr_in plus or minus the step, and ea equal to that new pointer.
- R6: Mode 5 gives ea = ptr_in + offset. Mode 6 gives ea = ptr_in + offset for bytes and ptr_in + 2*offset for words. Both leave ptr_out = ptr_in.
- R7: With mod_en=1, an increment whose result exceeds buf_end yields buf_start + (result - buf_end - 1).
- R8: With mod_en=1, a decrement whose result falls below buf_start yields buf_end - (buf_start - result - 1).
- R9: In the full variant, brev_en=1 with mode 1 replaces the stepped pointer. The new pointer comes from adding brev_mod with reversed carry over the low IDXW bits of the element index: the address for bytes, and address bits [AW-1:1] for words, with bit 0 kept. The upper bits are kept. This replacement takes precedence over modulo wrap. brev_en has no effect in any other mode.
- R10: A word access (byte_sel=0) whose ea is odd sets align_err=1 and gives ptr_out = ptr_in. A byte access never sets align_err.
- R11: In the reduced variant (HAS_BREV=0), brev_en and brev_mod have no effect: mode 1 behaves as in R4 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| ptr_in | input | AW | Current pointer register value |
| mode | input | 3 | Addressing mode, encodings as in R3 to R6 |
| offset | input | AW | Register or literal offset |
| byte_sel | input | 1 | 1 = byte access, 0 = word access |
| mod_en | input | 1 | Enable circular-buffer wrap |
| buf_start | input | AW | First address of circular buffer (inclusive) |
| buf_end | input | AW | Last address of circular buffer (inclusive) |
| brev_en | input | 1 | Enable bit-reversed post-increment |
| brev_mod | input | AW | Bit-reverse modifier, in address units |
| out_valid | output | 1 | Outputs carry a new result |
| ea | output | AW | Effective address |
| ptr_out | output | AW | Pointer value to write back |
| align_err | output | 1 | Word access at an odd address |

## Verification
Two functions can fall in the same cycle. The first pair is bit reversal and modulo wrap: a post-increment with both enables set, made on pointers at the top of the circular buffer where a plain step would wrap. The result must be the reversed-carry value, not the wrapped one. The second pair is a wrap and a misalignment: in word mode, odd pointers are stepped across both buffer edges. The flag must rise and the write-back must return the old pointer. The bench sweeps every pointer in a 64-byte buffer through all mode, size and enable combinations. It computes the reversed-carry result by bit-reversing, adding and reversing back, which is a different method from the carry chain in the design.

// File: rtl/agen_pkg.sv
package agen_pkg;

   typedef enum logic [2:0] {
      AM_PLAIN   = 3'd0,
      AM_POSTINC = 3'd1,
      AM_POSTDEC = 3'd2,
      AM_PREINC  = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_REGOFF  = 3'd5,
      AM_LITOFF  = 3'd6,
      AM_RSVD    = 3'd7
   } amode_e;

   function automatic logic is_step_up(amode_e m);
      return (m == AM_POSTINC) || (m == AM_PREINC);
   endfunction

   function automatic logic is_step_down(amode_e m);
      return (m == AM_POSTDEC) || (m == AM_PREDEC);
   endfunction

endpackage

// File: rtl/agen_step.sv
// Steps a pointer up or down, wrapping inside an inclusive [lo, hi] window.
module agen_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic          dec,
   input  logic          wrap,
   output logic [AW-1:0] nxt
);
   localparam int EW = AW + 1;
   localparam logic [EW-1:0] ONE = EW'(1);

   logic [EW-1:0] up_sum;
   logic [EW-1:0] floor_sum;
   logic [EW-1:0] overshoot;
   logic [EW-1:0] undershoot;
   logic          past_hi;
   logic          below_lo;

   always_comb begin
      up_sum     = {1'b0, ptr} + {1'b0, step};
      floor_sum  = {1'b0, lo} + {1'b0, step};
      overshoot  = up_sum - {1'b0, hi} - ONE;
      undershoot = floor_sum - {1'b0, ptr} - ONE;
      past_hi    = wrap && (up_sum > {1'b0, hi});
      below_lo   = wrap && ({1'b0, ptr} < floor_sum);
      if (!dec) begin
         nxt = past_hi ? (lo + overshoot[AW-1:0]) : up_sum[AW-1:0];
      end else begin
         nxt = below_lo ? (hi - undershoot[AW-1:0]) : (ptr - step);
      end
   end
endmodule

// File: rtl/agen_brev.sv
// Reversed-carry addition over the low IDXW bits of the element index.
module agen_brev #(
   parameter int AW   = 16,
   parameter int IDXW = 8
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] modv,
   input  logic          word,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0]   ix;
   logic [AW-1:0]   mx;
   logic [IDXW-1:0] fsum;
   logic [AW-1:0]   rebuilt;
   logic            cy;
   logic            unused_bits;

   always_comb begin
      ix = word ? (ptr >> 1)  : ptr;
      mx = word ? (modv >> 1) : modv;
      cy = 1'b0;
      for (int i = IDXW - 1; i >= 0; i--) begin
         fsum[i] = ix[i] ^ mx[i] ^ cy;
         cy      = (ix[i] & mx[i]) | (ix[i] & cy) | (mx[i] & cy);
      end
      rebuilt = {ix[AW-1:IDXW], fsum};
      nxt     = word ? {rebuilt[AW-2:0], ptr[0]} : rebuilt;
   end

   assign unused_bits = ^{mx[AW-1:IDXW], cy};
endmodule

// File: rtl/agen_port.sv
module agen_port #(
   parameter int AW       = 16,
   parameter int IDXW     = 8,
   parameter bit HAS_BREV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] ptr_in,
   input  logic [2:0]    mode,
   input  logic [AW-1:0] offset,
   input  logic          byte_sel,
   input  logic          mod_en,
   input  logic [AW-1:0] buf_start,
   input  logic [AW-1:0] buf_end,
   input  logic          brev_en,
   input  logic [AW-1:0] brev_mod,
   output logic          out_valid,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] ptr_out,
   output logic          align_err
);
   import agen_pkg::*;

   localparam logic [AW-1:0] STEP_B = AW'(1);
   localparam logic [AW-1:0] STEP_W = AW'(2);

   generate
      if (AW < 4) begin : g_bad_aw
         $error("agen_port: AW must be at least 4");
      end
      if (IDXW < 2 || IDXW >= AW) begin : g_bad_idxw
         $error("agen_port: IDXW must lie in [2, AW-1]");
      end
   endgenerate

   amode_e        am;
   logic [AW-1:0] step;
   logic [AW-1:0] step_nxt;
   logic [AW-1:0] brev_nxt;
   logic          brev_hit;
   logic [AW-1:0] moved;
   logic [AW-1:0] lit_off;
   logic [AW-1:0] ea_c;
   logic [AW-1:0] np_c;
   logic          err_c;

   assign am   = amode_e'(mode);
   assign step = byte_sel ? STEP_B : STEP_W;

   agen_step #(.AW(AW)) u_step (
      .ptr  (ptr_in),
      .step (step),
      .lo   (buf_start),
      .hi   (buf_end),
      .dec  (is_step_down(am)),
      .wrap (mod_en),
      .nxt  (step_nxt)
   );

   generate
      if (HAS_BREV) begin : g_full
         agen_brev #(.AW(AW), .IDXW(IDXW)) u_brev (
            .ptr  (ptr_in),
            .modv (brev_mod),
            .word (~byte_sel),
            .nxt  (brev_nxt)
         );
         assign brev_hit = brev_en && (am == AM_POSTINC);
      end else begin : g_lite
         logic unused_brev;
         assign brev_nxt    = step_nxt;
         assign brev_hit    = 1'b0;
         assign unused_brev = ^{brev_mod, brev_en};
      end
   endgenerate

   assign moved   = brev_hit ? brev_nxt : step_nxt;
   assign lit_off = byte_sel ? offset : {offset[AW-2:0], 1'b0};

   always_comb begin
      ea_c = ptr_in;
      np_c = ptr_in;
      unique case (am)
         AM_POSTINC, AM_POSTDEC: begin
            ea_c = ptr_in;
            np_c = moved;
         end
         AM_PREINC, AM_PREDEC: begin
            ea_c = moved;
            np_c = moved;
         end
         AM_REGOFF: ea_c = ptr_in + offset;
         AM_LITOFF: ea_c = ptr_in + lit_off;
         default: begin
            ea_c = ptr_in;
            np_c = ptr_in;
         end
      endcase
      err_c = !byte_sel && ea_c[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ea        <= '0;
         ptr_out   <= '0;
         align_err <= 1'b0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            ea        <= ea_c;
            ptr_out   <= err_c ? ptr_in : np_c;
            align_err <= err_c;
         end
      end
   end
endmodule

// File: rtl/agen_port_chk.sv
module agen_port_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] ptr_in,
   input logic [2:0]    mode,
   input logic          byte_sel,
   input logic          out_valid,
   input logic [AW-1:0] ea,
   input logic [AW-1:0] ptr_out,
   input logic          align_err
);
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && $stable(ea) && $stable(ptr_out) && $stable(align_err)));

   p_plain_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode == 3'd0 || mode == 3'd7)) |=>
         (ea == $past(ptr_in) && ptr_out == $past(ptr_in)));

   p_post_uses_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode == 3'd1 || mode == 3'd2)) |=> (ea == $past(ptr_in)));

   p_pre_uses_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode == 3'd3 || mode == 3'd4)) |=> (align_err || ea == ptr_out));

   p_offset_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode == 3'd5 || mode == 3'd6)) |=> (ptr_out == $past(ptr_in)));

   p_err_freezes_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !byte_sel) |=>
         (align_err == ea[0] && (!align_err || ptr_out == $past(ptr_in))));

   p_byte_never_errs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && byte_sel) |=> !align_err);
endmodule

bind agen_port agen_port_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .ptr_in    (ptr_in),
   .mode      (mode),
   .byte_sel  (byte_sel),
   .out_valid (out_valid),
   .ea        (ea),
   .ptr_out   (ptr_out),
   .align_err (align_err)
);

// File: tb/agen_port_test.sv
module agen_port_test;
   localparam int AW   = 16;
   localparam int IDXW = 6;
   localparam int LO   = 16'h0100;
   localparam int HI   = 16'h013F;
   localparam int BMOD = 16'h0020;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] ptr_in = '0;
   logic [2:0]    mode = '0;
   logic [AW-1:0] offset = '0;
   logic          byte_sel = 1'b0;
   logic          mod_en = 1'b0;
   logic [AW-1:0] buf_start = AW'(LO);
   logic [AW-1:0] buf_end = AW'(HI);
   logic          brev_en = 1'b0;
   logic [AW-1:0] brev_mod = AW'(BMOD);

   logic          f_valid, l_valid, f_err, l_err;
   logic [AW-1:0] f_ea, f_ptr, l_ea, l_ptr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   agen_port #(.AW(AW), .IDXW(IDXW), .HAS_BREV(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_in(ptr_in),
      .mode(mode), .offset(offset), .byte_sel(byte_sel), .mod_en(mod_en),
      .buf_start(buf_start), .buf_end(buf_end), .brev_en(brev_en),
      .brev_mod(brev_mod), .out_valid(f_valid), .ea(f_ea), .ptr_out(f_ptr),
      .align_err(f_err));

   agen_port #(.AW(AW), .IDXW(IDXW), .HAS_BREV(1'b0)) uut_lite (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ptr_in(ptr_in),
      .mode(mode), .offset(offset), .byte_sel(byte_sel), .mod_en(mod_en),
      .buf_start(buf_start), .buf_end(buf_end), .brev_en(brev_en),
      .brev_mod(brev_mod), .out_valid(l_valid), .ea(l_ea), .ptr_out(l_ptr),
      .align_err(l_err));

   function automatic int rev_field(int v);
      int r = 0;
      for (int i = 0; i < IDXW; i++) if (v[i]) r |= 1 << (IDXW - 1 - i);
      return r;
   endfunction

   // Expected result from the requirements; full selects the variant.
   task automatic model(input bit full, input int p, input int md, input int off,
                        input bit bsel, input bit men, input bit ben,
                        output int e_ea, output int e_ptr, output bit e_err,
                        output string tag);
      int st = bsel ? 1 : 2;
      int np = p;
      int ix, f, m, s;
      bit wrapped = 1'b0;
      bit brev = full && ben && (md == 1);
      tag = "R3";
      e_ea = p;
      if (md == 1 || md == 3) begin
         np = p + st;
         if (men && np > HI) begin np = LO + (np - HI - 1); wrapped = 1'b1; end
      end else if (md == 2 || md == 4) begin
         np = p - st;
         if (men && np < LO) begin np = HI - (LO - np - 1); wrapped = 1'b1; end
      end
      if (brev) begin
         ix = bsel ? p : (p >> 1);
         m  = bsel ? BMOD : (BMOD >> 1);
         f  = ix & ((1 << IDXW) - 1);
         s  = rev_field((rev_field(f) + rev_field(m & ((1 << IDXW) - 1))) & ((1 << IDXW) - 1));
         ix = (ix & ~((1 << IDXW) - 1)) | s;
         np = bsel ? ix : ((ix << 1) | (p & 1));
      end
      case (md)
         1, 2: begin e_ea = p;  tag = "R4"; end
         3, 4: begin e_ea = np; tag = "R5"; end
         5: begin e_ea = p + off; np = p; tag = "R6"; end
         6: begin e_ea = p + (bsel ? off : 2 * off); np = p; tag = "R6"; end
         default: begin e_ea = p; np = p; end
      endcase
      if (wrapped && !brev) tag = (md == 1 || md == 3) ? "R7" : "R8";
      if (brev) tag = "R9";
      if (!full && ben && md == 1) tag = "R11";
      e_ea  &= 16'hFFFF;
      np    &= 16'hFFFF;
      e_err = !bsel && e_ea[0];
      if (e_err) begin np = p; tag = "R10"; end
      e_ptr = np;
   endtask

   task automatic check(input string tag, input logic v, input logic [AW-1:0] a,
                        input logic [AW-1:0] pt, input logic er, input int xa,
                        input int xp, input bit xe);
      total++;
      if (v !== 1'b1 || a !== AW'(xa) || pt !== AW'(xp) || er !== xe) begin
         bad++;
         $display("FAIL %s: got v=%0b ea=%h ptr=%h err=%0b exp v=1 ea=%h ptr=%h err=%0b",
                  tag, v, a, pt, er, AW'(xa), AW'(xp), xe);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      total++;
      if (f_valid !== 1'b0 || f_ea !== '0 || f_ptr !== '0 || f_err !== 1'b0) begin
         bad++;
         $display("FAIL R1: got v=%0b ea=%h ptr=%h err=%0b exp all 0", f_valid, f_ea, f_ptr, f_err);
      end
      total++;
      if (l_valid !== 1'b0 || l_ea !== '0 || l_ptr !== '0 || l_err !== 1'b0) begin
         bad++;
         $display("FAIL R1: lite got v=%0b ea=%h ptr=%h err=%0b exp all 0", l_valid, l_ea, l_ptr, l_err);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int md = 0; md < 8; md++) begin
         for (int cfg = 0; cfg < 8; cfg++) begin
            for (int p = LO; p <= HI; p++) begin
               int xa, xp;
               bit xe;
               string tg;
               req_valid = 1'b1;
               ptr_in    = AW'(p);
               mode      = 3'(md);
               offset    = AW'((p * 3) & 16'h1F);
               byte_sel  = cfg[0];
               mod_en    = cfg[1];
               brev_en   = cfg[2];
               @(posedge clk);
               @(negedge clk);
               model(1'b1, p, md, (p * 3) & 16'h1F, cfg[0], cfg[1], cfg[2], xa, xp, xe, tg);
               check(tg, f_valid, f_ea, f_ptr, f_err, xa, xp, xe);
               model(1'b0, p, md, (p * 3) & 16'h1F, cfg[0], cfg[1], cfg[2], xa, xp, xe, tg);
               check(tg, l_valid, l_ea, l_ptr, l_err, xa, xp, xe);
            end
         end
      end

      // R2: idle cycle keeps outputs and drops out_valid
      begin
         logic [AW-1:0] kea, kpt;
         logic          ker;
         kea = f_ea; kpt = f_ptr; ker = f_err;
         req_valid = 1'b0;
         ptr_in    = 16'h0123;
         mode      = 3'd3;
         @(posedge clk);
         @(negedge clk);
         total++;
         if (f_valid !== 1'b0 || f_ea !== kea || f_ptr !== kpt || f_err !== ker) begin
            bad++;
            $display("FAIL R2: got v=%0b ea=%h ptr=%h err=%0b exp v=0 ea=%h ptr=%h err=%0b",
                     f_valid, f_ea, f_ptr, f_err, kea, kpt, ker);
         end
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule